// File: doc/BRIEF.md
# Nine-bit multiprocessor receive filter

This block sits after a UART receiver that runs with nine-bit characters: eight data bits plus a flag that marks the character as an address (flag set) or data (flag clear). For each received character it decides whether to pass it on and raise a receive interrupt request. The decision depends on a filter enable, a two-bit policy code and an eight-bit station address.

When the filter is off, every character passes. When it is on, the policy code picks one of four behaviours. It can pass everything, or pass only address characters. It can pass a matching address together with the data that follows it. It can pass only the data that follows a matching address. A single "selected" flag remembers whether the most recent address matched the station address. Each address character updates it, and a configuration change does not touch it.

The block also takes the transmit-side ninth-bit setting and the enable. It drives the ninth bit of outgoing characters, and forces that bit to zero while the filter is off.

Top module: `mp_rx_filter`

## Requirements
- R1: After reset, out_valid and irq are 0 and the selected flag is clear. Data characters arriving before any address are therefore dropped under policies 2 and 3.
- R2: With mp_en=0, every input character comes out two cycles after in_valid, with out_valid=1 and irq=1. The outgoing byte and flag are identical to the input.
- R3: Policy 0 (mode=2'b00) with mp_en=1 passes every character, address or data.
- R4: Policy 1 (mode=2'b01) with mp_en=1 passes only characters whose flag in_addr is 1.
- R5: Policy 2 (mode=2'b10) passes an address equal to match_addr and every data character after it. A non-matching address is dropped, and it stops the data that follows it.
- R6: Policy 3 (mode=2'b11) passes data characters only while the most recent address matched. Address characters themselves never pass.
- R7: An address character sets the selected flag when its byte equals match_addr, and clears the flag otherwise. Data characters and configuration changes leave the flag unchanged.
- R8: out_valid is high for exactly one clock per accepted character, and irq equals out_valid. A cycle without in_valid produces no output.
- R9: tx_bit9 equals tx_bit9_cfg when mp_en=1 and 0 when mp_en=0. It is registered with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received character strobe |
| in_data | input | DATA_W | Received data byte |
| in_addr | input | 1 | Ninth bit: 1 marks an address character |
| mp_en | input | 1 | Multiprocessor filter enable |
| mode | input | 2 | Filter policy code |
| match_addr | input | DATA_W | Station address compare value |
| tx_bit9_cfg | input | 1 | Ninth bit requested for transmit |
| out_valid | output | 1 | Accepted character strobe |
| out_data | output | DATA_W | Accepted data byte |
| out_addr | output | 1 | Accepted ninth bit |
| irq | output | 1 | Receive interrupt request |
| tx_bit9 | output | 1 | Ninth bit to transmitter |

## Verification
Some properties are checked on every cycle. Output strobes only appear two cycles after an input strobe, and irq always equals out_valid. With the filter off, every character is forwarded. Policy 1 never emits a data character, and policy 3 never emits an address. The transmit ninth bit is gated by the enable. The tracking behaviour of policies 2 and 3 needs the bench's mixed streams to show. This covers data before the first address, a change of station address in mid-stream, and a switch of policy with the selected flag kept. The bench checks these by comparing against its own model.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;
  typedef enum logic [1:0] {
    POL_ALL      = 2'b00,
    POL_ADDR     = 2'b01,
    POL_MATCH_TR = 2'b10,
    POL_DATA_SEL = 2'b11
  } policy_e;

  typedef struct packed {
    logic       addr;
    logic [7:0] data;
  } char_t;
endpackage

// File: rtl/mp_rx_input_stage.sv
module mp_rx_input_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_addr,
  output logic              s_valid,
  output logic [DATA_W-1:0] s_data,
  output logic              s_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_data  <= '0;
      s_addr  <= 1'b0;
    end else begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_data <= in_data;
        s_addr <= in_addr;
      end
    end
  end
endmodule

// File: rtl/mp_rx_decide.sv
module mp_rx_decide #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_addr,
  input  logic              mp_en,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] match_addr,
  output logic              accept,
  output logic              selected
);
  import mp_rx_pkg::*;

  logic hit;
  logic sel_next;

  assign hit = (s_data == match_addr);

  always_comb begin
    sel_next = selected;
    if (s_valid && s_addr) sel_next = hit;
  end

  always_comb begin
    accept = 1'b0;
    if (s_valid) begin
      if (!mp_en) accept = 1'b1;
      else begin
        unique case (policy_e'(mode))
          POL_ALL:      accept = 1'b1;
          POL_ADDR:     accept = s_addr;
          POL_MATCH_TR: accept = sel_next;
          POL_DATA_SEL: accept = !s_addr && selected;
          default:      accept = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) selected <= 1'b0;
    else     selected <= sel_next;
  end

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_addr) |=> $stable(selected));
  assert_sel_update_R7: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_addr) |=> (selected == $past(s_data == match_addr)));
endmodule

// File: rtl/mp_rx_output_stage.sv
module mp_rx_output_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_addr,
  input  logic              mp_en,
  input  logic              tx_bit9_cfg,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_addr,
  output logic              irq,
  output logic              tx_bit9
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      irq       <= 1'b0;
      out_data  <= '0;
      out_addr  <= 1'b0;
      tx_bit9   <= 1'b0;
    end else begin
      out_valid <= accept;
      irq       <= accept;
      tx_bit9   <= mp_en & tx_bit9_cfg;
      if (accept) begin
        out_data <= s_data;
        out_addr <= s_addr;
      end
    end
  end
endmodule

// File: rtl/mp_rx_filter.sv
module mp_rx_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_addr,
  input  logic              mp_en,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] match_addr,
  input  logic              tx_bit9_cfg,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_addr,
  output logic              irq,
  output logic              tx_bit9
);
  logic              s_valid;
  logic [DATA_W-1:0] s_data;
  logic              s_addr;
  logic              accept;
  logic              selected;

  mp_rx_input_stage #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_addr(in_addr), .s_valid(s_valid), .s_data(s_data), .s_addr(s_addr));

  mp_rx_decide #(.DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_addr(s_addr),
    .mp_en(mp_en), .mode(mode), .match_addr(match_addr),
    .accept(accept), .selected(selected));

  mp_rx_output_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .accept(accept), .s_data(s_data), .s_addr(s_addr),
    .mp_en(mp_en), .tx_bit9_cfg(tx_bit9_cfg), .out_valid(out_valid),
    .out_data(out_data), .out_addr(out_addr), .irq(irq), .tx_bit9(tx_bit9));

  assert_irq_eq_valid_R8: assert property (@(posedge clk) disable iff (rst)
    irq == out_valid);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  assert_pass_all_off_R2: assert property (@(posedge clk) disable iff (rst)
    (s_valid && !mp_en) |=> out_valid);
  assert_addr_only_R4: assert property (@(posedge clk) disable iff (rst)
    (s_valid && mp_en && mode == 2'b01) |=> (out_valid == $past(s_addr)));
  assert_no_addr_out_R6: assert property (@(posedge clk) disable iff (rst)
    (s_valid && mp_en && mode == 2'b11 && s_addr) |=> !out_valid);
  assert_tx9_gate_R9: assert property (@(posedge clk) disable iff (rst)
    tx_bit9 == $past(mp_en & tx_bit9_cfg));
endmodule

// File: tb/mp_rx_filter_bench.sv
module mp_rx_filter_bench;
  localparam int DATA_W = 8;
  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_addr = 0;
  logic mp_en = 0;
  logic [1:0] mode = 2'b00;
  logic [DATA_W-1:0] match_addr = '0;
  logic tx_bit9_cfg = 0;
  logic out_valid, out_addr, irq, tx_bit9;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int fails = 0;
  bit m_sel = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mp_rx_filter #(.DATA_W(DATA_W)) u_mp_rx_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_addr(in_addr), .mp_en(mp_en), .mode(mode), .match_addr(match_addr),
    .tx_bit9_cfg(tx_bit9_cfg), .out_valid(out_valid), .out_data(out_data),
    .out_addr(out_addr), .irq(irq), .tx_bit9(tx_bit9));

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sends one character, checks the output two cycles later against a model.
  task automatic send(input string req, input bit a, input logic [7:0] d);
    bit acc;
    bit sn;
    sn = a ? (d == match_addr) : m_sel;
    if (!mp_en) acc = 1;
    else case (mode)
      2'b00: acc = 1;
      2'b01: acc = a;
      2'b10: acc = sn;
      default: acc = !a && m_sel;
    endcase
    m_sel = sn;
    @(negedge clk);
    in_valid = 1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    check(req, {out_valid, irq, 8'h0}, {acc, acc, 8'h0});
    if (acc) check(req, {1'b0, out_addr, out_data}, {1'b0, a, d});
    @(negedge clk);
    check({req, " one-shot R8"}, {9'h0, out_valid}, 10'h0);
  endtask

  task automatic t_reset();
    check("R1", {8'h0, out_valid, irq}, 10'h0);
    mp_en = 1; mode = 2'b10; match_addr = 8'h5A;
    send("R1", 0, 8'h11);
    mode = 2'b11;
    send("R1", 0, 8'h12);
  endtask

  task automatic t_off();
    mp_en = 0;
    send("R2", 0, 8'h21); send("R2", 1, 8'h99); send("R2", 0, 8'hFE);
  endtask

  task automatic t_all();
    mp_en = 1; mode = 2'b00;
    send("R3", 1, 8'h33); send("R3", 0, 8'h34);
  endtask

  task automatic t_addr();
    mp_en = 1; mode = 2'b01;
    send("R4", 0, 8'h41); send("R4", 1, 8'h42); send("R4", 1, 8'h5A); send("R4", 0, 8'h43);
  endtask

  task automatic t_track();
    mp_en = 1; mode = 2'b10; match_addr = 8'h5A;
    send("R5", 1, 8'h07); send("R5", 0, 8'h51);
    send("R5", 1, 8'h5A); send("R5", 0, 8'h52); send("R5", 0, 8'h53);
    send("R5", 1, 8'h5B); send("R5", 0, 8'h54);
    send("R5", 1, 8'h5A); send("R5", 0, 8'h55);
  endtask

  task automatic t_datasel();
    mp_en = 1; mode = 2'b11;
    send("R6", 1, 8'h5A); send("R6", 0, 8'h61);
    // R7: change compare value, flag persists
    match_addr = 8'h77;
    send("R7", 0, 8'h62);
    send("R6", 1, 8'h5A); send("R6", 0, 8'h63);
    send("R6", 1, 8'h77); send("R6", 0, 8'h64);
    // R7: policy switch keeps flag
    mode = 2'b10;
    send("R7", 0, 8'h65);
  endtask

  task automatic t_tx9();
    mp_en = 1; tx_bit9_cfg = 1;
    @(negedge clk); @(negedge clk);
    check("R9", {9'h0, tx_bit9}, 10'h1);
    mp_en = 0;
    @(negedge clk);
    check("R9", {9'h0, tx_bit9}, 10'h0);
    tx_bit9_cfg = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset(); t_off(); t_all(); t_addr(); t_track(); t_datasel(); t_tx9();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule